// File: doc/BRIEF.md
# Bus-Mastering Block Copy Engine

This block copies a run of words from one region of memory to another over a system bus that it shares with a processor. Software loads a source address, a destination address and a word count, then sets a go bit. The engine asks for the bus with a request line and waits for the arbiter's grant. While it owns the bus, it moves each word with one read access at the source and one write access at the destination. It drives the address and write data, an active-low read/write select and an active-low access strobe.

A programmable burst size sets how long the engine holds the bus. With a burst size of zero, the engine keeps the bus from the first word to the last. With a nonzero burst size of B, the engine drops its request after every B words, which lets the processor use the bus. It then asks again and waits for a fresh grant before the next word. At the end of the transfer the engine sets a done flag and, if enabled, raises an interrupt. Software can abort a transfer that is running; the engine stops at the next word boundary.

Top module: `dma_engine`

## Requirements
- R1: After reset, every register reads zero, `bus_req`, `bus_own` and `irq` are low, and `bus_strobe_n` and `bus_rw_n` are high.
- R2: Register index 1 holds the source byte address, index 2 the word count and index 3 the destination byte address. Index 0 is control/status:
  - Write bits: bit 0 go, bit 1 abort, bit 2 interrupt enable, bit 3 clear done, bits 15:8 burst size.
  - Read bits: bit 0 busy, bit 2 interrupt enable, bit 3 done, bit 4 aborted, bits 15:8 burst size.
  - A register read returns its value on `cfg_rdata` one clock after `cfg_addr` is presented.
- R3: A go with a nonzero count sets busy and raises `bus_req`. No access strobe is driven unless both `bus_req` and `bus_grant` are high.
- R4: Each word is moved as a read cycle at the source address (`bus_rw_n` high, `bus_strobe_n` low) followed immediately by a write cycle at the destination address (`bus_rw_n` low) that carries the word just read. After the write, source and destination each advance by 4 and the count falls by 1.
- R5: With burst size 0, `bus_req` stays high from the first word to the last and falls exactly once per transfer.
- R6: With burst size B>0, no more than B words are moved per grant, and `bus_req` falls ceil(N/B) times for an N-word transfer.
- R7: Apart from an abort, `bus_req` falls only in the cycle right after a write access, which is the last access of a burst or of the transfer.
- R8: When the count reaches zero, busy clears and done sets. `irq` follows done ANDed with interrupt enable. A control write with bit 3 set clears done and aborted.
- R9: A go with a count of zero sets done at once without any bus request or access.
- R10: While busy, writes to the source, count, destination and control fields are ignored, and so is a second go.
- R11: An abort while busy ends the transfer after the word in progress. It sets done and aborted and leaves the registers showing the progress made, and no further words are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_addr` |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership grant from the arbiter |
| bus_own | output | 1 | High while the engine drives an access |
| bus_addr | output | AW | Access byte address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid during a read access |
| bus_rw_n | output | 1 | High for a read, low for a write |
| bus_strobe_n | output | 1 | Active-low access strobe |

## Verification
The bench builds the engine with 32-bit addresses and data, a 16-bit count and an 8-bit burst field, backed by a 256-word memory model and an arbiter model whose grant delay is set for each test. Burst sizes from 0 to 4 combined with counts from 1 to 20 produce partial final bursts, single-word bursts and runs longer than one burst. Long grant delays keep the engine busy long enough for mid-transfer register writes and aborts to land between words.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR, ST_GAP} dma_state_e;

  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_SRC  = 2'd1;
  localparam logic [1:0] IDX_LEN  = 2'd2;
  localparam logic [1:0] IDX_DST  = 2'd3;

  localparam int CB_GO    = 0;
  localparam int CB_STOP  = 1;
  localparam int CB_IEN   = 2;
  localparam int CB_CLR   = 3;
  localparam int CB_BURST = 8;

  localparam int SB_BUSY  = 0;
  localparam int SB_DONE  = 3;
  localparam int SB_ABRT  = 4;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LW     = 16,
  parameter int BW     = 8,
  parameter int REG_W  = 32,
  parameter int STRIDE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             busy,
  input  logic             advance,
  input  logic             finish,
  input  logic             finish_abort,
  output logic [AW-1:0]    src,
  output logic [AW-1:0]    dst,
  output logic [LW-1:0]    len,
  output logic [BW-1:0]    burst,
  output logic             start_p,
  output logic             abort_p,
  output logic [REG_W-1:0] rdata,
  output logic             irq
);
  logic irq_en, done_q, abrt_q;
  logic idle_wr;
  logic ctrl_hit;
  logic [REG_W-1:0] stat;

  assign idle_wr  = wr_en && !busy;
  assign ctrl_hit = (addr == IDX_CTRL);
  assign start_p  = idle_wr && ctrl_hit && wdata[CB_GO];
  assign abort_p  = wr_en && busy && ctrl_hit && wdata[CB_STOP];

  always_comb begin
    stat = '0;
    stat[SB_BUSY] = busy;
    stat[CB_IEN]  = irq_en;
    stat[SB_DONE] = done_q;
    stat[SB_ABRT] = abrt_q;
    stat[CB_BURST +: BW] = burst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src    <= '0;
      dst    <= '0;
      len    <= '0;
      burst  <= '0;
      irq_en <= 1'b0;
      done_q <= 1'b0;
      abrt_q <= 1'b0;
      irq    <= 1'b0;
      rdata  <= '0;
    end else begin
      if (advance) begin
        src <= src + AW'(STRIDE);
        dst <= dst + AW'(STRIDE);
        len <= len - LW'(1);
      end else if (idle_wr) begin
        case (addr)
          IDX_SRC: src <= wdata[AW-1:0];
          IDX_LEN: len <= wdata[LW-1:0];
          IDX_DST: dst <= wdata[AW-1:0];
          default: begin
            irq_en <= wdata[CB_IEN];
            burst  <= wdata[CB_BURST +: BW];
          end
        endcase
      end
      if (finish) begin
        done_q <= 1'b1;
        abrt_q <= finish_abort;
      end else if (idle_wr && ctrl_hit && (wdata[CB_CLR] || wdata[CB_GO])) begin
        done_q <= 1'b0;
        abrt_q <= 1'b0;
      end
      irq <= done_q && irq_en;
      case (addr)
        IDX_SRC: rdata <= REG_W'(src);
        IDX_LEN: rdata <= REG_W'(len);
        IDX_DST: rdata <= REG_W'(dst);
        default: rdata <= stat;
      endcase
    end
  end

  // R10
  hold_src_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && addr == IDX_SRC && !advance) |=> (src == $past(src)));

  // R8
  irq_done_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(done_q));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int LW     = 16,
  parameter int BW     = 8,
  parameter int STRIDE = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [LW-1:0] len,
  input  logic [BW-1:0] burst,
  input  logic          bus_grant,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          advance,
  output logic          finish,
  output logic          finish_abort,
  output logic          bus_req,
  output logic          bus_own,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_rw_n,
  output logic          bus_strobe_n
);
  dma_state_e state;
  logic [BW-1:0] cnt;
  logic abort_pend, abort_now, last_word, burst_end, waiting;

  assign abort_now = abort_pend || abort;
  assign last_word = (len == LW'(1));
  assign burst_end = (burst != '0) && (cnt == burst - BW'(1));
  assign waiting   = (state == ST_REQ) || (state == ST_GAP);
  assign busy      = (state != ST_IDLE);
  assign advance   = (state == ST_WR);
  assign finish    = ((state == ST_IDLE) && start && (len == '0)) ||
                     ((state == ST_WR) && (last_word || abort_now)) ||
                     (waiting && abort_now);
  assign finish_abort = finish && abort_now && busy && !((state == ST_WR) && last_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      abort_pend   <= 1'b0;
      bus_req      <= 1'b0;
      bus_own      <= 1'b0;
      bus_addr     <= '0;
      bus_wdata    <= '0;
      bus_rw_n     <= 1'b1;
      bus_strobe_n <= 1'b1;
    end else begin
      if (busy && abort) abort_pend <= 1'b1;
      case (state)
        ST_IDLE: begin
          abort_pend <= 1'b0;
          if (start && len != '0) begin
            state   <= ST_REQ;
            bus_req <= 1'b1;
            cnt     <= '0;
          end
        end
        ST_REQ: begin
          if (abort_now) begin
            state      <= ST_IDLE;
            bus_req    <= 1'b0;
            abort_pend <= 1'b0;
          end else if (bus_grant) begin
            state        <= ST_RD;
            bus_own      <= 1'b1;
            bus_addr     <= src;
            bus_rw_n     <= 1'b1;
            bus_strobe_n <= 1'b0;
          end
        end
        ST_RD: begin
          state     <= ST_WR;
          bus_addr  <= dst;
          bus_wdata <= bus_rdata;
          bus_rw_n  <= 1'b0;
        end
        ST_WR: begin
          bus_rw_n <= 1'b1;
          if (last_word || abort_now) begin
            state        <= ST_IDLE;
            bus_req      <= 1'b0;
            bus_own      <= 1'b0;
            bus_strobe_n <= 1'b1;
            abort_pend   <= 1'b0;
          end else if (burst_end) begin
            state        <= ST_GAP;
            bus_req      <= 1'b0;
            bus_own      <= 1'b0;
            bus_strobe_n <= 1'b1;
            cnt          <= '0;
          end else if (bus_grant) begin
            state    <= ST_RD;
            bus_addr <= src + AW'(STRIDE);
            cnt      <= cnt + BW'(1);
          end else begin
            state        <= ST_REQ;
            bus_own      <= 1'b0;
            bus_strobe_n <= 1'b1;
            cnt          <= cnt + BW'(1);
          end
        end
        default: begin
          if (abort_now) begin
            state      <= ST_IDLE;
            abort_pend <= 1'b0;
          end else begin
            state   <= ST_REQ;
            bus_req <= 1'b1;
          end
        end
      endcase
    end
  end

  // R3
  grant_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_strobe_n |-> (bus_grant && bus_req));

  // R4
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_strobe_n && bus_rw_n) |=> (!bus_strobe_n && !bus_rw_n));

  // R6
  burst_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (burst != '0 && !bus_strobe_n) |-> (cnt < burst));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_req) && !$past(abort_pend || abort)) |-> $past(!bus_strobe_n && !bus_rw_n));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int LW     = 16,
  parameter int BW     = 8,
  parameter int STRIDE = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr_en,
  input  logic [1:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          bus_own,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_rw_n,
  output logic          bus_strobe_n
);
  localparam int REG_W = 32;

  logic [AW-1:0] src, dst;
  logic [LW-1:0] len;
  logic [BW-1:0] burst;
  logic start_p, abort_p, busy, advance, finish, finish_abort;

  dma_regs #(.AW(AW), .LW(LW), .BW(BW), .REG_W(REG_W), .STRIDE(STRIDE)) regs_i (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .addr(cfg_addr), .wdata(cfg_wdata),
    .busy(busy), .advance(advance), .finish(finish), .finish_abort(finish_abort),
    .src(src), .dst(dst), .len(len), .burst(burst),
    .start_p(start_p), .abort_p(abort_p), .rdata(cfg_rdata), .irq(irq)
  );

  dma_seq #(.AW(AW), .DW(DW), .LW(LW), .BW(BW), .STRIDE(STRIDE)) seq_i (
    .clk(clk), .rst(rst), .start(start_p), .abort(abort_p),
    .src(src), .dst(dst), .len(len), .burst(burst),
    .bus_grant(bus_grant), .bus_rdata(bus_rdata),
    .busy(busy), .advance(advance), .finish(finish), .finish_abort(finish_abort),
    .bus_req(bus_req), .bus_own(bus_own), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rw_n(bus_rw_n), .bus_strobe_n(bus_strobe_n)
  );
endmodule

// File: tb/dma_engine_tb_top.sv
`timescale 1ns/1ps
module dma_engine_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        irq, bus_req, bus_own, bus_rw_n, bus_strobe_n;
  logic        bus_grant;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  logic [31:0] mem [0:255];
  int checks = 0;
  int errors = 0;
  int gmax = 0;
  logic [3:0] gw;

  dma_engine dut_i (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_grant(bus_grant), .bus_own(bus_own),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rw_n(bus_rw_n), .bus_strobe_n(bus_strobe_n)
  );

  assign bus_rdata = mem[bus_addr[9:2]];

  always @(posedge clk)
    if (!bus_strobe_n && !bus_rw_n) mem[bus_addr[9:2]] = bus_wdata;

  always @(posedge clk) begin
    if (rst || !bus_req) begin
      bus_grant <= 1'b0;
      gw <= '0;
    end else if (!bus_grant) begin
      if (int'(gw) >= gmax) bus_grant <= 1'b1;
      else gw <= gw + 4'd1;
    end
  end

  int mon_rd = 0, mon_wr = 0, mon_falls = 0, mon_badfall = 0, mon_bcur = 0, mon_bmax = 0;
  logic prev_req = 1'b0, prev_wr = 1'b0;
  always @(posedge clk) begin
    if (!rst) begin
      if (!bus_strobe_n && bus_rw_n) mon_rd++;
      if (!bus_strobe_n && !bus_rw_n) begin
        mon_wr++;
        mon_bcur++;
        if (mon_bcur > mon_bmax) mon_bmax = mon_bcur;
      end
      if (prev_req && !bus_req) begin
        mon_falls++;
        if (!prev_wr) mon_badfall++;
        mon_bcur = 0;
      end
    end
    prev_req = bus_req;
    prev_wr  = !bus_strobe_n && !bus_rw_n;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = a; cfg_wr_en = 1'b0;
    @(negedge clk);
    v = cfg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rd(2'd0, v);
      if (!v[0]) break;
    end
  endtask

  function automatic int exp_falls(input int n, input int b);
    return (b == 0) ? 1 : (n + b - 1) / b;
  endfunction

  function automatic int exp_bmax(input int n, input int b);
    return (b == 0 || b > n) ? n : b;
  endfunction

  task automatic fill(input int s, input int d, input int n);
    for (int i = 0; i <= n; i++) begin
      mem[s + i] = $urandom;
      mem[d + i] = 32'hDEAD0000 | i;
    end
  endtask

  task automatic run(input int s, input int d, input int n, input int b, input int ien, input int gm);
    logic [31:0] v;
    int r0, w0, f0, bad0, mism;
    gmax = gm;
    fill(s, d, n);
    wr(2'd1, s * 4); wr(2'd2, n); wr(2'd3, d * 4);
    wr(2'd0, (b << 8) | (ien << 2) | 8);
    r0 = mon_rd; w0 = mon_wr; f0 = mon_falls; bad0 = mon_badfall; mon_bmax = 0;
    wr(2'd0, (b << 8) | (ien << 2) | 1);
    wait_idle();
    mism = 0;
    for (int i = 0; i < n; i++) if (mem[d + i] !== mem[s + i]) mism++;
    chk("R4 copied data mismatches", mism, 0);
    chk("R11 no write past end", mem[d + n], 32'hDEAD0000 | n);
    rd(2'd1, v); chk("R4 final source", v, (s + n) * 4);
    rd(2'd3, v); chk("R4 final destination", v, (d + n) * 4);
    rd(2'd2, v); chk("R8 final count", v, 0);
    rd(2'd0, v); chk("R8 done bit", v[3], 1);
    chk("R2 burst field", v[15:8], b);
    chk("R8 irq", irq, ien[0]);
    chk("R4 read accesses", mon_rd - r0, n);
    chk("R4 write accesses", mon_wr - w0, n);
    chk(b == 0 ? "R5 releases" : "R6 releases", mon_falls - f0, exp_falls(n, b));
    chk("R6 max words per grant", mon_bmax, exp_bmax(n, b));
    chk("R7 release after write", mon_badfall - bad0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int r0, w0, f0, moved;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 bus_req", bus_req, 0);
    chk("R1 bus_own", bus_own, 0);
    chk("R1 strobe", bus_strobe_n, 1);
    chk("R1 rw", bus_rw_n, 1);
    chk("R1 irq", irq, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 register zero", v, 0);
    end

    // R2 readback while idle
    wr(2'd1, 32'h0000_0040); rd(2'd1, v); chk("R2 source readback", v, 32'h40);
    wr(2'd3, 32'h0000_0210); rd(2'd3, v); chk("R2 destination readback", v, 32'h210);

    // R5 continuous, R3 with grant delay
    run(0, 128, 5, 0, 1, 2);
    // R6 split bursts with partial last burst
    run(8, 140, 5, 2, 0, 1);
    run(20, 150, 7, 1, 1, 3);

    // R8 clearing done drops irq
    wr(2'd0, 32'h0000_0008);
    rd(2'd0, v); chk("R8 done cleared", v[3], 0);
    rd(2'd0, v); chk("R8 irq cleared", irq, 0);

    // R9 zero count
    wr(2'd2, 0);
    r0 = mon_rd; f0 = mon_falls;
    wr(2'd0, 32'h0000_0001);
    rd(2'd0, v);
    chk("R9 done at once", v[3], 1);
    chk("R9 not busy", v[0], 0);
    chk("R9 no request", mon_falls - f0, 0);
    chk("R9 no access", mon_rd - r0, 0);
    chk("R9 bus_req low", bus_req, 0);

    // R10 writes ignored while busy
    gmax = 3;
    fill(30, 170, 10);
    wr(2'd1, 30 * 4); wr(2'd2, 10); wr(2'd3, 170 * 4);
    wr(2'd0, 32'h0000_0208);
    wr(2'd0, 32'h0000_0201);
    wr(2'd1, 32'h0000_0300);
    wr(2'd2, 32'd1);
    wr(2'd3, 32'h0000_0380);
    wr(2'd0, 32'h0000_0701);
    rd(2'd0, v); chk("R10 still busy", v[0], 1);
    wait_idle();
    rd(2'd1, v); chk("R10 source unchanged by write", v, (30 + 10) * 4);
    rd(2'd3, v); chk("R10 destination unchanged by write", v, (170 + 10) * 4);
    rd(2'd0, v); chk("R10 burst field unchanged", v[15:8], 2);
    moved = 0;
    for (int i = 0; i < 10; i++) if (mem[170 + i] !== mem[30 + i]) moved++;
    chk("R10 full copy despite writes", moved, 0);

    // R11 abort mid-transfer
    gmax = 4;
    fill(40, 200, 20);
    wr(2'd1, 40 * 4); wr(2'd2, 20); wr(2'd3, 200 * 4);
    wr(2'd0, 32'h0000_0108);
    w0 = mon_wr;
    wr(2'd0, 32'h0000_0101);
    repeat (30) @(negedge clk);
    wr(2'd0, 32'h0000_0002);
    wait_idle();
    rd(2'd2, v); moved = 20 - int'(v);
    chk("R11 stopped early", (moved > 0 && moved < 20), 1);
    chk("R11 writes match progress", mon_wr - w0, moved);
    rd(2'd1, v); chk("R11 source shows progress", v, (40 + moved) * 4);
    rd(2'd3, v); chk("R11 destination shows progress", v, (200 + moved) * 4);
    chk("R11 next word untouched", mem[200 + moved], 32'hDEAD0000 | moved);
    rd(2'd0, v);
    chk("R11 aborted bit", v[4], 1);
    chk("R11 done bit", v[3], 1);

    // random mix
    for (int t = 0; t < 8; t++) begin
      run($urandom % 40, 128 + ($urandom % 40), 1 + $urandom % 12,
          $urandom % 5, $urandom % 2, $urandom % 4);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule